// File: doc/BRIEF.md
# Chip-by-Chip Soft Signal Estimator

This block is the per-chip soft estimator that sits between the chip deinterleaver and the per-user decoders of a multi-user interleave-division receiver. For each chip it takes one real received sample and the noise variance. It also takes, for every user, a real channel gain and the decoder's prior log-likelihood ratio for that user's chip. From these it forms a soft symbol and a residual variance for each user, builds the total received mean and variance, and then returns one extrinsic log-likelihood per user. Each user's extrinsic value is computed with the contributions of all other users cancelled out.

Work is done in two passes over the users. The accumulate pass takes one user per cycle and sums the received mean and variance. The emit pass then runs an iterative divide for each user and presents the results in user order on a valid/index handshake. A start pulse loads a chip. The busy flag covers the whole computation, and a new start is refused until the flag drops. All values are signed 16-bit two's complement with 12 fraction bits, so code 4096 means 1.0.

Top module: `ccse_estimator`

## Requirements
- R1: After reset, busy_o and ext_valid_o are low, ext_user_o is 0 and ext_llr_o is 0.
- R2: A user's soft symbol m is built from its prior L in three steps. (1) Take a = |L|. (2) If a ≥ 32768, m is ±4096. (3) Otherwise let s = a>>9 and f = a mod 512, and set m = T[s] + (((T[s+1]−T[s])·f)>>9). Here T[i] = round(4096·tanh(i/16)) for i = 0..64. The sign of m follows L. A prior of 0 (the first iteration) therefore gives m = 0.
- R3: A user's residual variance is v = 4096 − ((m·m)>>12).
- R4: The received mean is E = Σ ((h_k·m_k)>>12). The received variance is V = noise + Σ ((((h_k·h_k)>>12)·v_k)>>12). Every >> is an arithmetic (floor) shift.
- R5: Let p = 2·h_k·(r − E + ((h_k·m_k)>>12)) and d = V − ((((h_k·h_k)>>12)·v_k)>>12). The extrinsic magnitude is floor(|p|/d), and its sign is negative exactly when p < 0.
- R6: When d ≤ 0, the value 1 is used in place of d.
- R7: A magnitude above 32767 is saturated to 32767 for both signs, so the code −32768 never appears.
- R8: One chip yields exactly NUM_USERS outputs. Each output has ext_valid_o high for one cycle and ext_user_o counting 0, 1, … in order.
- R9: busy_o is high from the cycle after an accepted start through the cycle of the last output, and low in the cycle after that.
- R10: A start_i asserted while busy_o is high has no effect. The outputs of the chip in flight are unchanged, and no extra chip is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the chip presented on the data inputs |
| rx_i | input | W | Received sample |
| coef_i | input | NUM_USERS*W | Channel gain per user, user k in bits [k*W +: W] |
| llr_i | input | NUM_USERS*W | Prior log-likelihood per user, same packing |
| noise_var_i | input | W | Noise variance |
| busy_o | output | 1 | Chip in progress |
| ext_valid_o | output | 1 | Extrinsic output valid |
| ext_user_o | output | UW | User index of the current output |
| ext_llr_o | output | W | Extrinsic log-likelihood |

## Verification
The first pattern is a sweep of priors across the whole 16-bit range, stepping the gains and received sample along with it. It exercises every lookup segment, both signs and the saturation point of the soft-symbol lookup, so it exposes a wrong table, a wrong interpolation or a wrong variance. A pattern with all priors at zero isolates the first-iteration path, where every user has zero mean and unit variance. Patterns with negative noise variance and with hard priors force the denominator to zero or below, which separates the clamp from the output saturation. A last pattern pulses start with different data mid-chip; it shows whether the captured chip is protected and whether the busy flag and output order stay correct.

// File: rtl/ccse_pkg.sv
package ccse_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_ISSUE,
    ST_WAIT
  } est_state_e;
endpackage

// File: rtl/ccse_tanh_lut.sv
module ccse_tanh_lut #(
  parameter int W        = 16,
  parameter int FRAC     = 12,
  parameter int SEG_BITS = 6
) (
  input  logic signed [W-1:0] llr_i,
  output logic signed [W-1:0] mean_o
);
  localparam int NSEG      = 1 << SEG_BITS;
  localparam int SPAN_BITS = FRAC + 3;            // input span 8.0
  localparam int FB        = SPAN_BITS - SEG_BITS;
  localparam int ONE       = 1 << FRAC;
  localparam logic signed [W-1:0] ONE_Q = W'(ONE);

  function automatic int knot(int i);
    real x;
    x = (8.0 * i) / NSEG;
    return $rtoi($tanh(x / 2.0) * ONE + 0.5);
  endfunction

  logic [W-1:0] tab [NSEG+1];
  for (genvar g = 0; g <= NSEG; g++) begin : g_knot
    localparam int KV = knot(g);
    assign tab[g] = W'(KV);
  end

  logic signed [W:0]    llr_x;
  logic [W:0]           mag;
  logic [SEG_BITS-1:0]  seg;
  logic [FB-1:0]        fr;
  logic [W-1:0]         lo, hi, delta, y;
  logic [W+FB-1:0]      slope;
  logic                 sat;

  always_comb begin
    llr_x = (W+1)'(llr_i);
    mag   = llr_x[W] ? unsigned'(-llr_x) : unsigned'(llr_x);
    sat   = |mag[W:SPAN_BITS];
    seg   = mag[SPAN_BITS-1 -: SEG_BITS];
    fr    = mag[FB-1:0];
    lo    = tab[seg];
    hi    = tab[(SEG_BITS+1)'(seg) + (SEG_BITS+1)'(1)];
    delta = hi - lo;
    slope = (W+FB)'(delta) * (W+FB)'(fr);
    y     = sat ? W'(ONE) : lo + W'(slope >> FB);
    mean_o = llr_i[W-1] ? -signed'(y) : signed'(y);
  end

  always_comb begin
    a_r2_mean_bounded: assert (mean_o <= ONE_Q && mean_o >= -ONE_Q)
      else $error("soft mean out of range");
  end
endmodule

// File: rtl/ccse_divider.sv
module ccse_divider #(
  parameter int NW    = 49,
  parameter int DEN_W = 32,
  parameter int QW    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NW-1:0]     num_i,
  input  logic [DEN_W-1:0]  den_i,
  output logic              done_o,
  output logic [QW-1:0]     quot_o,
  output logic              ovf_o
);
  localparam int CW = (QW > 1) ? $clog2(QW) : 1;
  localparam int XW = NW + QW;

  logic [NW-1:0]    rem_q;
  logic [DEN_W-1:0] dvs_q;
  logic [QW-1:0]    quot_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q, done_q, ovf_q;
  logic [XW-1:0]    trial;
  logic             take;

  assign trial = XW'(dvs_q) << cnt_q;
  assign take  = XW'(rem_q) >= trial;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quot_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= num_i;
        dvs_q  <= den_i;
        quot_q <= '0;
        cnt_q  <= CW'(QW - 1);
        run_q  <= 1'b1;
        ovf_q  <= XW'(num_i) >= (XW'(den_i) << QW);
      end else if (run_q) begin
        if (take) begin
          rem_q         <= rem_q - NW'(trial);
          quot_q[cnt_q] <= 1'b1;
        end
        if (cnt_q == '0) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quot_q;
  assign ovf_o  = ovf_q;

  a_r6_divisor_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> den_i != '0);
  a_r5_rem_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !ovf_o |-> NW'(dvs_q) > rem_q);
endmodule

// File: rtl/ccse_estimator.sv
module ccse_estimator
  import ccse_pkg::*;
#(
  parameter int NUM_USERS = 4,
  parameter int W         = 16,
  parameter int FRAC      = 12,
  localparam int UW       = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic signed [W-1:0]       rx_i,
  input  logic [NUM_USERS*W-1:0]    coef_i,
  input  logic [NUM_USERS*W-1:0]    llr_i,
  input  logic signed [W-1:0]       noise_var_i,
  output logic                      busy_o,
  output logic                      ext_valid_o,
  output logic [UW-1:0]             ext_user_o,
  output logic signed [W-1:0]       ext_llr_o
);
  localparam int AW  = 2 * W;
  localparam int PW  = 3 * W;
  localparam int DW  = AW + W + 1;
  localparam int ONE = 1 << FRAC;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [UW-1:0] LAST = UW'(NUM_USERS - 1);

  est_state_e state_q;
  logic [UW-1:0]         idx_q;
  logic signed [W-1:0]   rx_q;
  logic signed [W-1:0]   coef_q [NUM_USERS];
  logic signed [W-1:0]   llr_q  [NUM_USERS];
  logic signed [AW-1:0]  hm_q   [NUM_USERS];
  logic signed [AW-1:0]  hv_q   [NUM_USERS];
  logic signed [AW-1:0]  er_q, vr_q;
  logic                  neg_q;
  logic                  accept;

  // accumulate pass
  logic signed [W-1:0]   mean_c, var_c, h_c;
  logic signed [AW-1:0]  m_sq, hm_c, hh_c, hv_c;
  logic signed [PW-1:0]  hv_p;

  ccse_tanh_lut #(.W(W), .FRAC(FRAC), .SEG_BITS(6)) u_lut (
    .llr_i  (llr_q[idx_q]),
    .mean_o (mean_c)
  );

  always_comb begin
    h_c   = coef_q[idx_q];
    m_sq  = AW'(mean_c) * AW'(mean_c);
    var_c = W'(ONE) - W'(m_sq >>> FRAC);
    hm_c  = (AW'(h_c) * AW'(mean_c)) >>> FRAC;
    hh_c  = (AW'(h_c) * AW'(h_c)) >>> FRAC;
    hv_p  = PW'(hh_c) * PW'(var_c);
    hv_c  = AW'(hv_p >>> FRAC);
  end

  // emit pass
  logic signed [AW-1:0]  a_c, den_c;
  logic signed [DW-1:0]  prod_c;
  logic [DW-1:0]         mag_c;
  logic [AW-1:0]         den_pos;
  logic                  div_start, div_done, div_ovf;
  logic [W-1:0]          div_quot, res_mag;

  always_comb begin
    a_c     = AW'(rx_q) - er_q + hm_q[idx_q];
    prod_c  = (DW'(coef_q[idx_q]) * DW'(a_c)) <<< 1;
    mag_c   = prod_c[DW-1] ? unsigned'(-prod_c) : unsigned'(prod_c);
    den_c   = vr_q - hv_q[idx_q];
    den_pos = (den_c > 0) ? unsigned'(den_c) : AW'(1);
    res_mag = (div_ovf || div_quot > MAXP) ? MAXP : div_quot;
  end

  assign div_start = (state_q == ST_ISSUE);

  ccse_divider #(.NW(DW), .DEN_W(AW), .QW(W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (mag_c),
    .den_i   (den_pos),
    .done_o  (div_done),
    .quot_o  (div_quot),
    .ovf_o   (div_ovf)
  );

  assign busy_o = (state_q != ST_IDLE) || ext_valid_o;
  assign accept = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      rx_q        <= '0;
      er_q        <= '0;
      vr_q        <= '0;
      neg_q       <= 1'b0;
      ext_valid_o <= 1'b0;
      ext_user_o  <= '0;
      ext_llr_o   <= '0;
      for (int u = 0; u < NUM_USERS; u++) begin
        coef_q[u] <= '0;
        llr_q[u]  <= '0;
        hm_q[u]   <= '0;
        hv_q[u]   <= '0;
      end
    end else begin
      ext_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          rx_q  <= rx_i;
          er_q  <= '0;
          vr_q  <= AW'(noise_var_i);
          idx_q <= '0;
          for (int u = 0; u < NUM_USERS; u++) begin
            coef_q[u] <= coef_i[u*W +: W];
            llr_q[u]  <= llr_i[u*W +: W];
          end
          state_q <= ST_ACC;
        end
        ST_ACC: begin
          hm_q[idx_q] <= hm_c;
          hv_q[idx_q] <= hv_c;
          er_q        <= er_q + hm_c;
          vr_q        <= vr_q + hv_c;
          if (idx_q == LAST) begin
            idx_q   <= '0;
            state_q <= ST_ISSUE;
          end else begin
            idx_q <= idx_q + UW'(1);
          end
        end
        ST_ISSUE: begin
          neg_q   <= prod_c[DW-1];
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (div_done) begin
          ext_valid_o <= 1'b1;
          ext_user_o  <= idx_q;
          ext_llr_o   <= neg_q ? -signed'(res_mag) : signed'(res_mag);
          if (idx_q == LAST) begin
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + UW'(1);
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(rx_q));
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |=> !ext_valid_o);
  a_r8_user_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |-> ext_user_o <= LAST);
  a_r7_symmetric_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |-> ext_llr_o != {1'b1, {(W-1){1'b0}}});
  a_r9_busy_ends_on_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(ext_valid_o));
endmodule

// File: tb/ccse_estimator_tb.sv
module ccse_estimator_tb_top;
  localparam int K = 4;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [W-1:0] rx = '0, noise = '0;
  logic [K*W-1:0] coef = '0, llr = '0;
  logic busy, valid;
  logic [1:0] user;
  logic signed [W-1:0] ext;

  int n_run = 0, n_fail = 0;
  longint tab [65];

  always #5 clk = ~clk;

  ccse_estimator #(.NUM_USERS(K), .W(W), .FRAC(12)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rx_i(rx),
    .coef_i(coef), .llr_i(llr), .noise_var_i(noise),
    .busy_o(busy), .ext_valid_o(valid), .ext_user_o(user), .ext_llr_o(ext)
  );

  task automatic check(string req, longint act, longint expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint soft_mean(longint l);
    longint a, s, f, y;
    a = (l < 0) ? -l : l;
    if (a >= 32768) y = 4096;
    else begin
      s = a >> 9;
      f = a % 512;
      y = tab[s] + (((tab[s+1] - tab[s]) * f) >>> 9);
    end
    return (l < 0) ? -y : y;
  endfunction

  task automatic run_chip(string req, longint r, longint h [K], longint l [K],
                          longint nv, bit disturb);
    longint m [K], v [K], hm [K], hv [K], e [K];
    longint er, vr, p, d, q;
    int got, cyc;
    er = 0;
    vr = nv;
    for (int k = 0; k < K; k++) begin
      m[k]  = soft_mean(l[k]);
      v[k]  = 4096 - ((m[k] * m[k]) >>> 12);
      hm[k] = (h[k] * m[k]) >>> 12;
      hv[k] = (((h[k] * h[k]) >>> 12) * v[k]) >>> 12;
      er += hm[k];
      vr += hv[k];
    end
    for (int k = 0; k < K; k++) begin
      p = 2 * h[k] * (r - er + hm[k]);
      d = vr - hv[k];
      if (d <= 0) d = 1;
      q = ((p < 0) ? -p : p) / d;
      if (q > 32767) q = 32767;
      e[k] = (p < 0) ? -q : q;
    end
    @(negedge clk);
    rx = W'(r);
    noise = W'(nv);
    for (int k = 0; k < K; k++) begin
      coef[k*W +: W] = W'(h[k]);
      llr[k*W +: W]  = W'(l[k]);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 busy after start", busy, 1);
    got = 0;
    cyc = 0;
    while (got < K && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc >= 3 && cyc <= 6) begin
        start = 1'b1;
        rx = ~rx;
        llr = ~llr;
      end else begin
        start = 1'b0;
      end
      if (valid) begin
        check("R8 user order", user, got);
        check(req, ext, e[got]);
        if (got == K - 1) check("R9 busy on last", busy, 1);
        got++;
      end
    end
    start = 1'b0;
    if (got < K) check("R8 output count", got, K);
    @(negedge clk);
    check(disturb ? "R10 no extra chip" : "R9 busy drop", busy, 0);
    check("R8 no extra valid", valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    longint h [K], l [K];
    for (int i = 0; i <= 64; i++)
      tab[i] = longint'($rtoi($tanh(i / 16.0) * 4096.0 + 0.5));
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 valid", valid, 0);
    check("R1 user", user, 0);
    check("R1 llr", ext, 0);
    rst_n = 1'b1;

    // R4 R5: first iteration, zero priors
    h = '{4096, 2048, -1024, 512};
    l = '{0, 0, 0, 0};
    run_chip("R4 R5 zero prior", 3000, h, l, 820, 1'b0);
    h = '{-3000, 700, 4096, -8192};
    run_chip("R5 zero prior", -5000, h, l, 100, 1'b0);

    // R2 R3: prior sweep over full range
    for (int i = 0; i < 256; i++) begin
      l[0] = -32768 + i * 257;
      l[1] = 32767 - i * 257;
      l[2] = ((i * 1237) % 65536) - 32768;
      l[3] = (i % 2) ? 0 : -l[2] + ((l[2] == -32768) ? -1 : 0);
      h[0] = 4096;
      h[1] = -2048 - i * 8;
      h[2] = 1000 + i * 40;
      h[3] = -300;
      run_chip("R2 R3 prior sweep", ((i * 331) % 16384) - 8192, h, l, 410, 1'b0);
    end

    // R6: denominator zero and negative
    h = '{4096, 4096, 4096, 4096};
    l = '{-32768, -32768, -32768, -32768};
    run_chip("R6 R7 zero denominator", 100, h, l, 0, 1'b0);
    h = '{1024, -512, 256, 2048};
    l = '{0, 0, 0, 0};
    run_chip("R6 negative denominator", 2000, h, l, -32768, 1'b0);

    // R7: large magnitudes, both signs
    h = '{32767, -32768, 20000, -20000};
    l = '{-32768, 32767, -32768, 32767};
    run_chip("R7 saturation", -32768, h, l, 1, 1'b0);
    h = '{16, -16, 8192, 100};
    l = '{5000, -5000, 0, 12};
    run_chip("R7 R5 mixed", 32767, h, l, 4096, 1'b0);

    // R10: start pulses while busy
    h = '{4096, -2048, 1500, 300};
    l = '{8000, -12000, 2000, 0};
    run_chip("R10 ignored start", 1234, h, l, 600, 1'b1);
    run_chip("R10 follow-up", -4321, h, l, 600, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule